// File: doc/BRIEF.md
# Bit-Field Insert, Extract and Scan Unit

This unit performs field and masked-logic operations on a word-wide memory operand. A one-byte field descriptor selects a contiguous run of bits. The low half of the descriptor gives the lowest bit of the run. The high half gives the run length minus one. Four operations work on that run: depositing accumulator bits into it, pulling it out right-justified, and locating the first one or the first zero inside it. Three further operations combine the accumulator with the memory operand under a per-bit mask, and change only the bits the mask selects.

A request is presented with a one-cycle `start` pulse. Results are registered, `done` pulses in the following cycle, and the outputs hold until the next request. The surrounding pipeline supplies the operands and writes back `mem_out` and `acc_out`. It traps when `illegal` is raised.

Top module: `bfu_unit`

## Requirements
- R1: While reset is asserted, and after it, `done`, `illegal`, `mem_out` and `acc_out` are all zero until the first request.
- R2: `done` is high in exactly the cycle after a cycle with `start` high. All outputs keep their values in every cycle that does not follow a `start`.
- R3: Descriptor bits [3:0] give the field's lowest bit `s`, and bits [7:4] give `L-1` for field length `L`. For opcodes 0 to 3, a descriptor with `s + (L-1) > 15` raises `illegal`.
- R4: Opcode 0 (deposit) returns `mem_in` with bits `s..s+L-1` replaced by accumulator bits `0..L-1`. For example, 0x00F0 with accumulator 3 and descriptor 0x32 gives 0x00CC.
- R5: Opcode 1 (pull) returns in `acc_out` the field of `mem_in`, shifted down to bit 0, with every higher bit zero. For example, 0x00CC with descriptor 0x32 gives 3.
- R6: Opcodes 2 (seek one) and 3 (seek zero) return in `acc_out` the offset of the first matching bit of the field. With `scan_dir` = 0 the search starts at bit `s` and rises, and offset 0 is bit `s`. With `scan_dir` = 1 it starts at bit `s+L-1` and falls, and offset 0 is that bit.
- R7: When no bit in the field matches, the seek opcodes return `L+1`.
- R8: Opcodes 4, 5 and 6 replace each `mem_in` bit whose `mask_in` bit is one with its AND, OR or XOR with the accumulator bit, respectively. Bits whose mask bit is zero are kept.
- R9: Opcodes 7 to 15 raise `illegal`. On any illegal request, `mem_out` equals `mem_in` and `acc_out` equals `acc_in`.
- R10: Deposit and the masked opcodes return `acc_in` unchanged in `acc_out`. Pull and seek return `mem_in` unchanged in `mem_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, one cycle |
| op | input | 4 | Operation code |
| desc | input | 8 | Field descriptor: lowest bit and length minus one |
| scan_dir | input | 1 | Seek direction: 0 rising, 1 falling |
| acc_in | input | 16 | Accumulator operand |
| mem_in | input | 16 | Memory operand |
| mask_in | input | 16 | Per-bit select for the masked opcodes |
| done | output | 1 | Result valid strobe |
| illegal | output | 1 | Request was rejected |
| mem_out | output | 16 | New memory value |
| acc_out | output | 16 | New accumulator value |

## Verification
The bench builds the unit at its default 16-bit width. At that width the descriptor has only 256 codes, so every code is swept for deposit, pull and both seek opcodes in both directions, against several memory patterns. The sweep reaches every out-of-range descriptor, every field that touches bit 15, and many not-found seeks. The masked and reserved opcodes run over pseudo-random operands, and the worked deposit and pull examples are checked explicitly.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
   localparam int unsigned OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      BF_DEPOSIT = 4'd0,
      BF_PULL    = 4'd1,
      BF_SEEK1   = 4'd2,
      BF_SEEK0   = 4'd3,
      BF_MAND    = 4'd4,
      BF_MOR     = 4'd5,
      BF_MXOR    = 4'd6
   } bfu_op_e;
endpackage

// File: rtl/bfu_field_mask.sv
module bfu_field_mask #(
   parameter int unsigned DATA_W = 16,
   localparam int unsigned POS_W = $clog2(DATA_W)
) (
   input  logic [POS_W-1:0]  fstart,
   input  logic [POS_W-1:0]  flenm1,
   output logic [DATA_W-1:0] fmask,
   output logic [DATA_W-1:0] jmask,
   output logic              fits
);
   localparam int unsigned SUM_W = POS_W + 1;

   logic [SUM_W-1:0] fend;
   assign fend = {1'b0, fstart} + {1'b0, flenm1};
   assign fits = (fend <= SUM_W'(DATA_W - 1));

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam logic [SUM_W-1:0] BIDX = SUM_W'(b);
      assign jmask[b] = (BIDX <= {1'b0, flenm1});
      assign fmask[b] = (BIDX >= {1'b0, fstart}) && (BIDX <= fend);
   end
endmodule

// File: rtl/bfu_scan.sv
module bfu_scan #(
   parameter int unsigned DATA_W = 16,
   localparam int unsigned POS_W = $clog2(DATA_W),
   localparam int unsigned CNT_W = POS_W + 1
) (
   input  logic [DATA_W-1:0] fbits,
   input  logic [DATA_W-1:0] jmask,
   input  logic [POS_W-1:0]  flenm1,
   input  logic              want_one,
   input  logic              from_top,
   output logic [CNT_W-1:0]  pos
);
   logic [DATA_W-1:0] hits;
   logic [POS_W-1:0]  lo_idx;
   logic [POS_W-1:0]  hi_idx;

   assign hits = want_one ? (fbits & jmask) : (~fbits & jmask);

   always_comb begin
      lo_idx = '0;
      hi_idx = '0;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         if (hits[i]) lo_idx = POS_W'(i);
      end
      for (int i = 0; i < DATA_W; i++) begin
         if (hits[i]) hi_idx = POS_W'(i);
      end
   end

   always_comb begin
      if (hits == '0)
         pos = {1'b0, flenm1} + CNT_W'(2);
      else if (from_top)
         pos = {1'b0, flenm1 - hi_idx};
      else
         pos = {1'b0, lo_idx};
   end
endmodule

// File: rtl/bfu_unit.sv
module bfu_unit
   import bfu_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   localparam int unsigned POS_W = $clog2(DATA_W),
   localparam int unsigned DESC_W = 2 * POS_W,
   localparam int unsigned CNT_W = POS_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OP_W-1:0]   op,
   input  logic [DESC_W-1:0] desc,
   input  logic              scan_dir,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] mem_in,
   input  logic [DATA_W-1:0] mask_in,
   output logic              done,
   output logic              illegal,
   output logic [DATA_W-1:0] mem_out,
   output logic [DATA_W-1:0] acc_out
);
   if (DATA_W < 8 || (1 << POS_W) != DATA_W) begin : g_bad_cfg
      $error("bfu_unit: DATA_W must be a power of two of at least 8");
   end

   logic [POS_W-1:0]  fstart;
   logic [POS_W-1:0]  flenm1;
   logic [DATA_W-1:0] fmask;
   logic [DATA_W-1:0] jmask;
   logic              fits;
   logic [DATA_W-1:0] justified;
   logic [CNT_W-1:0]  seek_pos;
   logic              is_field;
   logic              is_reserved;
   bfu_op_e           opc;

   assign fstart = desc[POS_W-1:0];
   assign flenm1 = desc[DESC_W-1:POS_W];
   assign opc = bfu_op_e'(op);
   assign is_field = (op <= OP_W'(BF_SEEK0));
   assign is_reserved = (op > OP_W'(BF_MXOR));

   bfu_field_mask #(.DATA_W(DATA_W)) u_mask (
      .fstart (fstart),
      .flenm1 (flenm1),
      .fmask  (fmask),
      .jmask  (jmask),
      .fits   (fits)
   );

   assign justified = (mem_in >> fstart) & jmask;

   bfu_scan #(.DATA_W(DATA_W)) u_scan (
      .fbits    (justified),
      .jmask    (jmask),
      .flenm1   (flenm1),
      .want_one (opc == BF_SEEK1),
      .from_top (scan_dir),
      .pos      (seek_pos)
   );

   logic [DATA_W-1:0] nxt_mem;
   logic [DATA_W-1:0] nxt_acc;
   logic              nxt_ill;

   always_comb begin
      nxt_mem = mem_in;
      nxt_acc = acc_in;
      nxt_ill = 1'b0;
      if (is_reserved || (is_field && !fits)) begin
         nxt_ill = 1'b1;
      end else begin
         case (opc)
            BF_DEPOSIT: nxt_mem = (mem_in & ~fmask) | ((acc_in << fstart) & fmask);
            BF_PULL:    nxt_acc = justified;
            BF_SEEK1,
            BF_SEEK0:   nxt_acc = DATA_W'(seek_pos);
            BF_MAND:    nxt_mem = (mem_in & ~mask_in) | (mem_in & acc_in & mask_in);
            BF_MOR:     nxt_mem = (mem_in & ~mask_in) | ((mem_in | acc_in) & mask_in);
            BF_MXOR:    nxt_mem = (mem_in & ~mask_in) | ((mem_in ^ acc_in) & mask_in);
            default:    nxt_ill = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done    <= 1'b0;
         illegal <= 1'b0;
         mem_out <= '0;
         acc_out <= '0;
      end else begin
         done <= start;
         if (start) begin
            illegal <= nxt_ill;
            mem_out <= nxt_mem;
            acc_out <= nxt_acc;
         end
      end
   end
endmodule

// File: rtl/bfu_unit_chk.sv
module bfu_unit_chk #(
   parameter int unsigned DATA_W = 16,
   localparam int unsigned POS_W = $clog2(DATA_W),
   localparam int unsigned DESC_W = 2 * POS_W,
   localparam int unsigned SUM_W = POS_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [3:0]        op,
   input logic [DESC_W-1:0] desc,
   input logic [DATA_W-1:0] acc_in,
   input logic [DATA_W-1:0] mem_in,
   input logic [DATA_W-1:0] mask_in,
   input logic              done,
   input logic              illegal,
   input logic [DATA_W-1:0] mem_out,
   input logic [DATA_W-1:0] acc_out
);
   logic [DATA_W-1:0] low_ones;
   logic [DATA_W-1:0] seek_lim;
   logic              out_of_range;

   assign low_ones = ~({DATA_W{1'b1}} << ({1'b0, desc[DESC_W-1:POS_W]} + 1'b1));
   assign seek_lim = DATA_W'({1'b0, desc[DESC_W-1:POS_W]}) + DATA_W'(2);
   assign out_of_range = ({1'b0, desc[POS_W-1:0]} + {1'b0, desc[DESC_W-1:POS_W]})
                         > SUM_W'(DATA_W - 1);

   AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> done); // R2
   AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(start)); // R2
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !start |=> ($stable(mem_out) && $stable(acc_out) && $stable(illegal))); // R2
   AST_RANGE_TRAP: assert property (@(posedge clk) disable iff (!rst_n) (start && op <= 4'd3 && out_of_range) |=> illegal); // R3
   AST_RESERVED_TRAP: assert property (@(posedge clk) disable iff (!rst_n) (start && op > 4'd6) |=> (illegal && mem_out == $past(mem_in) && acc_out == $past(acc_in))); // R9
   AST_PULL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (start && op == 4'd1 && !out_of_range) |=> ((acc_out & ~$past(low_ones)) == '0)); // R5
   AST_SEEK_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (start && (op == 4'd2 || op == 4'd3) && !out_of_range) |=> (acc_out <= $past(seek_lim))); // R7
   AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (start && op >= 4'd4 && op <= 4'd6) |=> (((mem_out ^ $past(mem_in)) & ~$past(mask_in)) == '0)); // R8
   AST_READ_KEEPS_MEM: assert property (@(posedge clk) disable iff (!rst_n) (start && op >= 4'd1 && op <= 4'd3) |=> (mem_out == $past(mem_in))); // R10
endmodule

bind bfu_unit bfu_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .op      (op),
   .desc    (desc),
   .acc_in  (acc_in),
   .mem_in  (mem_in),
   .mask_in (mask_in),
   .done    (done),
   .illegal (illegal),
   .mem_out (mem_out),
   .acc_out (acc_out)
);

// File: tb/bfu_unit_test.sv
module bfu_unit_test;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [3:0]   op = '0;
   logic [7:0]   desc = '0;
   logic         scan_dir = 1'b0;
   logic [W-1:0] acc_in = '0;
   logic [W-1:0] mem_in = '0;
   logic [W-1:0] mask_in = '0;
   logic         done;
   logic         illegal;
   logic [W-1:0] mem_out;
   logic [W-1:0] acc_out;

   int n_checks = 0;
   int n_fails = 0;
   bit finished = 1'b0;
   logic [15:0] seed = 16'hACE1;

   always #5 clk = ~clk;

   bfu_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .desc(desc),
      .scan_dir(scan_dir), .acc_in(acc_in), .mem_in(mem_in), .mask_in(mask_in),
      .done(done), .illegal(illegal), .mem_out(mem_out), .acc_out(acc_out)
   );

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s op=%0d desc=%h dir=%0d actual=%h expected=%h",
                  tag, op, desc, scan_dir, act, exp);
      end
   endtask

   function automatic logic [15:0] next_rand();
      seed = {seed[14:0], seed[15] ^ seed[13] ^ seed[12] ^ seed[10]};
      return seed;
   endfunction

   task automatic ref_model(input int opv, input logic [7:0] d, input logic dir,
                            input logic [W-1:0] a, input logic [W-1:0] m, input logic [W-1:0] k,
                            output logic [W-1:0] em, output logic [W-1:0] ea, output logic ei);
      int st, lm1, ln, p;
      st = int'(d[3:0]);
      lm1 = int'(d[7:4]);
      ln = lm1 + 1;
      em = m;
      ea = a;
      ei = 1'b0;
      if (opv > 6 || (opv < 4 && st + lm1 > 15)) begin
         ei = 1'b1;
      end else if (opv == 0) begin
         for (int j = 0; j < ln; j++) em[st + j] = a[j];
      end else if (opv == 1) begin
         ea = '0;
         for (int j = 0; j < ln; j++) ea[j] = m[st + j];
      end else if (opv == 2 || opv == 3) begin
         ea = W'(ln + 1);
         for (int j = ln - 1; j >= 0; j--) begin
            p = dir ? (st + lm1 - j) : (st + j);
            if (m[p] == (opv == 2)) ea = W'(j);
         end
      end else begin
         for (int i = 0; i < W; i++) begin
            if (k[i]) begin
               if (opv == 4) em[i] = m[i] & a[i];
               else if (opv == 5) em[i] = m[i] | a[i];
               else em[i] = m[i] ^ a[i];
            end
         end
      end
   endtask

   task automatic xact(input int opv, input logic [7:0] d, input logic dir,
                       input logic [W-1:0] a, input logic [W-1:0] m, input logic [W-1:0] k);
      logic [W-1:0] em, ea;
      logic ei;
      string mtag, atag, itag;
      ref_model(opv, d, dir, a, m, k, em, ea, ei);
      itag = "R3";
      if (opv > 6) begin mtag = "R9"; atag = "R9"; itag = "R9"; end
      else if (ei) begin mtag = "R3"; atag = "R3"; end
      else if (opv == 0) begin mtag = "R4"; atag = "R10"; end
      else if (opv == 1) begin mtag = "R10"; atag = "R5"; end
      else if (opv <= 3) begin
         mtag = "R10";
         atag = (ea == W'(int'(d[7:4]) + 2)) ? "R7" : "R6";
      end else begin mtag = "R8"; atag = "R10"; end
      @(negedge clk);
      op = 4'(opv); desc = d; scan_dir = dir; acc_in = a; mem_in = m; mask_in = k;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R2 done", W'(done), W'(1));
      check(itag, W'(illegal), W'(ei));
      check(mtag, mem_out, em);
      check(atag, acc_out, ea);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [W-1:0] pats [4];
      logic [W-1:0] hm, ha;
      repeat (3) @(negedge clk);
      check("R1 done", W'(done), W'(0));
      check("R1 illegal", W'(illegal), W'(0));
      check("R1 mem", mem_out, '0);
      check("R1 acc", acc_out, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 post", mem_out | acc_out | W'(done), '0);

      // worked examples
      xact(0, 8'h32, 1'b0, 16'h0003, 16'h00F0, '0);
      check("R4 example", mem_out, 16'h00CC);
      xact(1, 8'h32, 1'b0, 16'hFFFF, 16'h00CC, '0);
      check("R5 example", acc_out, 16'h0003);

      // hold: idle cycles keep outputs, done low
      hm = mem_out; ha = acc_out;
      @(negedge clk);
      @(negedge clk);
      check("R2 hold done", W'(done), W'(0));
      check("R2 hold mem", mem_out, hm);
      check("R2 hold acc", acc_out, ha);

      pats[0] = 16'h0000;
      pats[1] = 16'hFFFF;
      pats[2] = 16'h8421;
      // full descriptor sweep for field ops (R3 R4 R5 R6 R7 R10)
      for (int dsc = 0; dsc < 256; dsc++) begin
         pats[3] = next_rand();
         for (int pi = 0; pi < 4; pi++) begin
            xact(0, 8'(dsc), 1'b0, next_rand(), pats[pi], next_rand());
            xact(1, 8'(dsc), 1'b0, next_rand(), pats[pi], next_rand());
            for (int dr = 0; dr < 2; dr++) begin
               xact(2, 8'(dsc), dr[0], next_rand(), pats[pi], next_rand());
               xact(3, 8'(dsc), dr[0], next_rand(), pats[pi], next_rand());
            end
         end
      end

      // masked logic (R8 R10), descriptor irrelevant
      for (int n = 0; n < 60; n++) begin
         for (int o = 4; o <= 6; o++) begin
            xact(o, next_rand()[7:0], 1'b0, next_rand(), next_rand(), next_rand());
         end
      end
      xact(5, 8'hFF, 1'b0, 16'hFFFF, 16'h0000, 16'h0000);
      check("R8 mask zero keeps", mem_out, 16'h0000);

      // reserved opcodes (R9)
      for (int o = 7; o < 16; o++) begin
         for (int n = 0; n < 4; n++) begin
            xact(o, next_rand()[7:0], n[0], next_rand(), next_rand(), next_rand());
         end
      end

      @(negedge clk);
      finish_run();
   end
endmodule